// File: doc/BRIEF.md
# Nibble-Merge External Memory Write Port

This block is an auto-stepping write port into a memory of 16-bit words. A host loads a mode word and a start address. After that, each data strobe writes one word at the current address, and the address then moves on by a step that the mode chooses. Three stepping schemes exist:
- a linear signed increment;
- a "cell" stride for tiled graphics, which adds 1 from an even address and 31 from an odd one;
- a separate instruction-RAM target, which uses the linear increment and is flagged when the address lies outside its 1 K-word window.

An optional overwrite mode turns a write into a read-modify-write. Only the nonzero nibbles of the incoming word replace the stored nibbles.

The memory side is a single bus. It has a read strobe, whose data returns one cycle later, a write strobe, an address, write data and a target select. While an overwrite write waits for its read data, `busy` is high. Loading a new mode and address discards any write that is pending.

Top module: `nibble_write_port`

## Requirements
- R1: After reset, `busy`, `mem_we`, `mem_re` and `addr_bad` are 0. The reset mode is unsupported, so a strobe before the first load causes no bus activity.
- R2: `cfg_load` sets the address and mode used by the next write. A strobe in the same cycle as a load is dropped. A load while `busy` is high cancels the pending write, so no `mem_we` is issued in that cycle.
- R3: Linear external mode is selected when mode[14]=0 and mode[9:0]=0x018. With mode[10]=0, an accepted strobe raises `mem_we` in the same cycle, with `mem_addr` equal to the current address, `mem_wdata` equal to `wr_data` and `mem_iram`=0.
- R4: The increment code mode[13:11] maps values 0..7 to steps of 0, 1, 2, 4, 8, 16, 32 and 128 words. mode[15]=1 makes the step a decrement. The address wraps modulo 2^16 after each write.
- R5: Cell mode is selected when mode[14]=1 and mode[9:0]=0x018. After each write the address advances by 31 if it was odd and by 1 if it was even.
- R6: With mode[10]=1 in linear or cell mode, an accepted strobe raises only `mem_re` at the current address. In the next cycle `busy` is 1 and `mem_we` is raised at the same address.
- R7: In an overwrite write, each 4-bit nibble of `mem_wdata` is the incoming nibble if that nibble is nonzero. Otherwise it is the nibble read on `mem_rdata`.
- R8: Instruction-RAM mode is selected when mode[14]=0 and mode[10:0]=0x01c. Writes are plain, with `mem_iram`=1, and the address follows the linear increment of R4.
- R9: `addr_bad` pulses with an instruction-RAM write whose address bits [15:10] are not 100000b. The write is still issued.
- R10: A strobe in any other mode causes no bus activity and leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load mode and start address |
| cfg_mode | input | 16 | Mode word |
| cfg_addr | input | 16 | Start word address |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | 16 | Data to write |
| busy | output | 1 | Overwrite write is waiting for its read data |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_iram | output | 1 | Write targets the instruction RAM |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| addr_bad | output | 1 | Instruction-RAM address outside its window |

## Verification
The assertions check the following on every cycle:
- the read and write strobes never overlap;
- a read is always followed by a busy cycle that writes to the unchanged address, unless a load cancels it;
- each nonzero held nibble reaches `mem_wdata`;
- the cell stride follows the parity of the address;
- `addr_bad` appears only together with an instruction-RAM write.

Only the bench scenarios can show the rest:
- the full increment table, including the signs and the wrap;
- that a dropped or cancelled write leaves the loaded address in force;
- that unsupported modes stay silent;
- that zero nibbles keep the stored data.

// File: rtl/nwp_pkg.sv
package nwp_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_LIN  = 2'd1,
    TGT_CELL = 2'd2,
    TGT_IRAM = 2'd3
  } nwp_tgt_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_MERGE = 1'b1
  } nwp_state_e;
endpackage

// File: rtl/nwp_decode.sv
module nwp_decode
  import nwp_pkg::*;
#(
  parameter int MODE_W = 16,
  parameter int MAG_W  = 8
) (
  input  logic [MODE_W-1:0] mode,
  output nwp_tgt_e          tgt,
  output logic              ovr,
  output logic [MAG_W-1:0]  inc_mag,
  output logic              inc_neg
);
  logic [2:0] code;

  always_comb begin
    code    = mode[13:11];
    inc_neg = mode[15];
    ovr     = mode[10];
    case (code)
      3'd0:    inc_mag = MAG_W'(0);
      3'd7:    inc_mag = MAG_W'(128);
      default: inc_mag = MAG_W'(1) << (code - 3'd1);
    endcase
    if (!mode[14] && mode[10:0] == 11'h01c)
      tgt = TGT_IRAM;
    else if (mode[9:0] == 10'h018)
      tgt = mode[14] ? TGT_CELL : TGT_LIN;
    else
      tgt = TGT_NONE;
  end
endmodule

// File: rtl/nwp_step.sv
module nwp_step
  import nwp_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int MAG_W       = 8,
  parameter int CELL_STRIDE = 31
) (
  input  logic [ADDR_W-1:0] addr,
  input  nwp_tgt_e          tgt,
  input  logic [MAG_W-1:0]  inc_mag,
  input  logic              inc_neg,
  output logic [ADDR_W-1:0] addr_nxt
);
  localparam logic [ADDR_W-1:0] ODD_STEP = ADDR_W'(CELL_STRIDE);
  logic [ADDR_W-1:0] mag_ext;

  always_comb begin
    mag_ext = ADDR_W'(inc_mag);
    case (tgt)
      TGT_LIN, TGT_IRAM: addr_nxt = inc_neg ? addr - mag_ext : addr + mag_ext;
      TGT_CELL:          addr_nxt = addr + (addr[0] ? ODD_STEP : ADDR_W'(1));
      default:           addr_nxt = addr;
    endcase
  end
endmodule

// File: rtl/nwp_merge.sv
module nwp_merge #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  output logic [DATA_W-1:0] merged
);
  localparam int NIBBLES = DATA_W / NIB_W;

  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    assign merged[g*NIB_W +: NIB_W] = (new_word[g*NIB_W +: NIB_W] != '0)
                                      ? new_word[g*NIB_W +: NIB_W]
                                      : old_word[g*NIB_W +: NIB_W];
  end
endmodule

// File: rtl/nibble_write_port.sv
module nibble_write_port
  import nwp_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 16,
  parameter int                MODE_W      = 16,
  parameter int                NIB_W       = 4,
  parameter int                CELL_STRIDE = 31,
  parameter logic [ADDR_W-1:0] IRAM_BASE   = 16'h8000,
  parameter logic [ADDR_W-1:0] IRAM_MASK   = 16'hfc00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              mem_re,
  output logic              mem_we,
  output logic              mem_iram,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              addr_bad
);
  localparam int MAG_W   = 8;
  localparam int NIBBLES = DATA_W / NIB_W;

  nwp_state_e        state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n, addr_step;
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] hold_q, merged;
  logic              hold_en;
  nwp_tgt_e          tgt;
  logic              ovr, inc_neg, accept;
  logic [MAG_W-1:0]  inc_mag;

  nwp_decode #(.MODE_W(MODE_W), .MAG_W(MAG_W)) u_dec (
    .mode(mode_q), .tgt(tgt), .ovr(ovr), .inc_mag(inc_mag), .inc_neg(inc_neg)
  );

  nwp_step #(.ADDR_W(ADDR_W), .MAG_W(MAG_W), .CELL_STRIDE(CELL_STRIDE)) u_step (
    .addr(addr_q), .tgt(tgt), .inc_mag(inc_mag), .inc_neg(inc_neg), .addr_nxt(addr_step)
  );

  nwp_merge #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_merge (
    .old_word(mem_rdata), .new_word(hold_q), .merged(merged)
  );

  assign busy     = (state_q == ST_MERGE);
  assign mem_addr = addr_q;
  assign accept   = wr_valid && !busy && !cfg_load && (tgt != TGT_NONE);

  always_comb begin
    state_n   = state_q;
    addr_n    = addr_q;
    hold_en   = 1'b0;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_iram  = 1'b0;
    mem_wdata = wr_data;
    addr_bad  = 1'b0;
    if (cfg_load) begin
      state_n = ST_IDLE;
      addr_n  = cfg_addr;
    end else if (state_q == ST_MERGE) begin
      mem_we    = 1'b1;
      mem_wdata = merged;
      addr_n    = addr_step;
      state_n   = ST_IDLE;
    end else if (accept) begin
      if (ovr && tgt != TGT_IRAM) begin
        mem_re  = 1'b1;
        hold_en = 1'b1;
        state_n = ST_MERGE;
      end else begin
        mem_we   = 1'b1;
        mem_iram = (tgt == TGT_IRAM);
        addr_bad = (tgt == TGT_IRAM) && ((addr_q & IRAM_MASK) != IRAM_BASE);
        addr_n   = addr_step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      mode_q  <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_n;
      addr_q  <= addr_n;
      if (cfg_load) mode_q <= cfg_mode;
      if (hold_en)  hold_q <= wr_data;
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we)); // R6
  AST_RD_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> busy); // R6
  AST_RD_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_addr == $past(mem_addr))); // R6
  AST_BUSY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_load) |-> (mem_we && !mem_iram)); // R6
  AST_LOAD_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> !mem_we); // R2
  AST_BAD_ONLY_IRAM: assert property (@(posedge clk) disable iff (!rst_n)
    addr_bad |-> (mem_we && mem_iram)); // R9
  AST_CELL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && tgt == TGT_CELL && !cfg_load) |=>
      (mem_addr == $past(mem_addr) + ($past(mem_addr[0]) ? ADDR_W'(CELL_STRIDE) : ADDR_W'(1)))); // R5

  for (genvar g = 0; g < NIBBLES; g++) begin : g_chk
    AST_NIB_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cfg_load && hold_q[g*NIB_W +: NIB_W] != '0) |->
        (mem_wdata[g*NIB_W +: NIB_W] == hold_q[g*NIB_W +: NIB_W])); // R7
  end
endmodule

// File: tb/nibble_write_port_test.sv
module nibble_write_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_mode = '0, cfg_addr = '0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0, mem_rdata = '0;
  logic        busy, mem_re, mem_we, mem_iram, addr_bad;
  logic [15:0] mem_addr, mem_wdata;

  int checks = 0, errors = 0;
  logic [15:0] m_mode, m_addr;

  nibble_write_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode), .cfg_addr(cfg_addr),
    .wr_valid(wr_valid), .wr_data(wr_data), .busy(busy), .mem_re(mem_re), .mem_we(mem_we),
    .mem_iram(mem_iram), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .addr_bad(addr_bad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // 0 none, 1 linear, 2 cell, 3 iram
  function automatic int kind(input logic [15:0] m);
    if (!m[14] && m[10:0] == 11'h01c) return 3;
    if (m[9:0] == 10'h018) return m[14] ? 2 : 1;
    return 0;
  endfunction

  function automatic logic [15:0] next_addr(input logic [15:0] m, input logic [15:0] a);
    logic [15:0] mag;
    int k = kind(m);
    case (m[13:11])
      3'd0: mag = 0;   3'd1: mag = 1;  3'd2: mag = 2;  3'd3: mag = 4;
      3'd4: mag = 8;   3'd5: mag = 16; 3'd6: mag = 32; default: mag = 128;
    endcase
    if (k == 2) return a + (a[0] ? 16'd31 : 16'd1);
    if (k == 0) return a;
    return m[15] ? a - mag : a + mag;
  endfunction

  function automatic logic [15:0] nib_merge(input logic [15:0] old, input logic [15:0] nw);
    logic [15:0] r;
    for (int i = 0; i < 4; i++)
      r[i*4 +: 4] = (nw[i*4 +: 4] != 0) ? nw[i*4 +: 4] : old[i*4 +: 4];
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] m, input logic [15:0] a);
    @(negedge clk);
    cfg_load = 1'b1; cfg_mode = m; cfg_addr = a;
    @(negedge clk);
    cfg_load = 1'b0;
    m_mode = m; m_addr = a;
  endtask

  task automatic do_write(input logic [15:0] d, input logic [15:0] rv);
    int k = kind(m_mode);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; #1;
    if (k == 0) begin
      chk(!mem_we && !mem_re, "R10 silent", {mem_we, mem_re}, 0);
      @(negedge clk); wr_valid = 1'b0;
    end else if (m_mode[10] && k != 3) begin
      chk(mem_re && !mem_we, "R6 read", {mem_re, mem_we}, 2'b10);
      chk(mem_addr == m_addr, "R6 rd addr", mem_addr, m_addr);
      @(negedge clk); wr_valid = 1'b0; mem_rdata = rv; #1;
      chk(busy && mem_we, "R6 busy write", {busy, mem_we}, 2'b11);
      chk(mem_addr == m_addr, "R6 wr addr", mem_addr, m_addr);
      chk(mem_wdata == nib_merge(rv, d), "R7 merge", mem_wdata, nib_merge(rv, d));
      m_addr = next_addr(m_mode, m_addr);
      @(negedge clk);
    end else begin
      chk(mem_we && !mem_re, "R3 write", {mem_we, mem_re}, 2'b10);
      chk(mem_addr == m_addr, (k == 2) ? "R5 addr" : "R4 addr", mem_addr, m_addr);
      chk(mem_wdata == d, "R3 data", mem_wdata, d);
      chk(mem_iram == (k == 3), "R8 target", mem_iram, k == 3);
      chk(addr_bad == (k == 3 && m_addr[15:10] != 6'b100000), "R9 addr_bad",
          addr_bad, k == 3 && m_addr[15:10] != 6'b100000);
      m_addr = next_addr(m_mode, m_addr);
      @(negedge clk); wr_valid = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_mode = '0; m_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !mem_we && !mem_re && !addr_bad, "R1 reset", {busy, mem_we, mem_re, addr_bad}, 0);
    rst_n = 1'b1;
    do_write(16'h1111, 0); // R1: reset mode is unsupported

    // R4: every increment code, both signs, with wrap
    for (int c = 0; c < 8; c++) begin
      load(16'h0018 | 16'(c << 11), 16'h0003);
      do_write(16'hA000 + 16'(c), 0);
      do_write(16'hB000 + 16'(c), 0);
      load(16'h8018 | 16'(c << 11), 16'h0001);
      do_write(16'hC000, 0);
      do_write(16'hD000, 0);
    end
    // R5: cell from even and odd
    load(16'h4018, 16'h0010);
    repeat (4) do_write(16'h5555, 0);
    load(16'h4018, 16'h0021);
    repeat (3) do_write(16'h6666, 0);
    // R8/R9: iram valid then outside window
    load(16'h081c, 16'h83fe);
    repeat (3) do_write(16'h7777, 0);
    // R6/R7: overwrite corners
    load(16'h0c18, 16'h0100);
    do_write(16'h0F00, 16'h1234);
    do_write(16'h0000, 16'hBEEF);
    do_write(16'hFFFF, 16'h0000);
    // R2: write in the same cycle as a load is dropped
    @(negedge clk);
    cfg_load = 1'b1; cfg_mode = 16'h0818; cfg_addr = 16'h0200; wr_valid = 1'b1; wr_data = 16'h9999; #1;
    chk(!mem_we && !mem_re, "R2 drop", {mem_we, mem_re}, 0);
    @(negedge clk); cfg_load = 1'b0; wr_valid = 1'b0;
    m_mode = 16'h0818; m_addr = 16'h0200;
    do_write(16'h4321, 0);
    // R2: load during a pending merge cancels it
    load(16'h0c18, 16'h0300);
    @(negedge clk); wr_valid = 1'b1; wr_data = 16'h00F0;
    @(negedge clk); wr_valid = 1'b0; cfg_load = 1'b1; cfg_mode = 16'h0818; cfg_addr = 16'h0400; #1;
    chk(!mem_we, "R2 cancel", mem_we, 0);
    @(negedge clk); cfg_load = 1'b0; #1;
    chk(!busy && !mem_we, "R2 idle", {busy, mem_we}, 0);
    m_mode = 16'h0818; m_addr = 16'h0400;
    do_write(16'h2468, 0);
    // R10
    load(16'h00f5, 16'h0050);
    do_write(16'h1357, 0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [15:0] m, a;
      int t = $urandom_range(0, 3);
      m = 16'($urandom());
      a = 16'($urandom());
      case (t)
        0: m[9:0] = 10'h0f5;
        1: begin m[14] = 1'b0; m[9:0] = 10'h018; end
        2: begin m[14] = 1'b1; m[9:0] = 10'h018; end
        default: begin
          m[14] = 1'b0; m[10:0] = 11'h01c;
          if ($urandom_range(0, 1) == 1) a = 16'h8000 | (a & 16'h03ff);
        end
      endcase
      load(m, a);
      repeat ($urandom_range(1, 4)) do_write(16'($urandom()), 16'($urandom()));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule